// File: doc/BRIEF.md
# Scaled 64-bit System Counter

This block is a shared timestamp source for the other timer blocks on a chip. It holds the time in an 88-bit fixed-point accumulator. The upper 64 bits are the visible count, and the lower 24 bits are a fraction. While the counter is enabled, each pulse on the reference tick input advances the accumulator. With scaling off, a pulse adds exactly one to the visible count. With scaling on, a pulse adds a programmable 32-bit increment to the accumulator, so the count can run at a fractional or a multiple rate of the tick.

Software reaches the block through a simple 32-bit register port that has two frames. The control frame holds a control word, the low and high halves of the count, and the scale increment. The status frame always reads zero, because halting on debug is not built. The full 64-bit count also drives a dedicated output for consumers.

Control frame word offsets: 0 is control, 1 is count bits [31:0], 2 is count bits [63:32], 3 is scale. In the control word, bit 0 enables counting and bit 1 enables scaling. All other offsets read zero and ignore writes.

Top module: `scaled_sys_counter`

## Requirements
- R1: After reset, the count is zero, the control word reads 0, and the scale register reads 0x0100_0000 (unity scaling).
- R2: While control bit 0 is clear, ticks leave the count and its fraction unchanged.
- R3: With counting enabled and control bit 1 clear, each tick adds exactly one to the 64-bit count.
- R4: With control bit 1 set, each tick adds the scale value to the 88-bit accumulator, and the count equals its top 64 bits. For example, scale 0x0080_0000 gives one count per two ticks and scale 0x0300_0000 gives three counts per tick.
- R5: A write to offset 1 replaces count bits [31:0], leaves bits [63:32] unchanged, and clears the fraction.
- R6: A write to offset 2 replaces count bits [63:32], leaves bits [31:0] unchanged, and clears the fraction.
- R7: A count write in the same cycle as an enabled tick takes priority, so the written value is taken with no increment added.
- R8: Control word bits [31:2] read zero and ignore writes.
- R9: Every read of the status frame returns zero, and so does every unused control-frame offset (4 to 7).
- R10: The count carries from bit 31 into bit 32 and keeps counting upward without stopping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference tick; one pulse advances the accumulator |
| bus_wr | input | 1 | Register write strobe |
| bus_frame | input | 1 | Frame select: 0 is control, 1 is status |
| bus_addr | input | 3 | Word offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| count_out | output | 64 | Visible 64-bit count for consumers |

## Verification
Two events can fall in the same cycle: a software write to one half of the count, and a reference tick that would advance the accumulator. The bench makes them collide by raising the tick on the exact cycle of a count write while counting is enabled. It passes if the count read back afterwards is the written value with no increment. It then sends one more tick to show that counting resumes from an exact integer with no leftover fraction. The count is never checked after the scale value changes while counting is enabled, because the count is undefined at that point.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    // Word offsets inside the control frame
    typedef enum logic [2:0] {
        OFS_CTRL  = 3'd0,
        OFS_CNTLO = 3'd1,
        OFS_CNTHI = 3'd2,
        OFS_SCALE = 3'd3
    } ssc_ofs_e;

    // Stored control bits (everything else in the word is read-as-zero)
    typedef struct packed {
        logic scl_en;
        logic cnt_en;
    } ssc_ctrl_t;

    // Increment equal to one whole count for a given fraction width
    function automatic logic [31:0] unity_scale(input int frac_w);
        return 32'(1) << frac_w;
    endfunction

endpackage

// File: rtl/ssc_regfile.sv
module ssc_regfile
    import ssc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 64,
    parameter int FRAC_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_frame,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count_in,
    output ssc_ctrl_t         ctrl_o,
    output logic [DATA_W-1:0] scale_o,
    output logic              wr_lo_o,
    output logic              wr_hi_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [DATA_W-1:0] SCALE_RST = DATA_W'(unity_scale(FRAC_W));

    ssc_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] scale_q;
    logic              wr_ctl;
    logic              wr_ctrl;
    logic              wr_scale;

    assign wr_ctl   = bus_wr && !bus_frame;
    assign wr_ctrl  = wr_ctl && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_scale = wr_ctl && (bus_addr == ADDR_W'(OFS_SCALE));
    assign wr_lo_o  = wr_ctl && (bus_addr == ADDR_W'(OFS_CNTLO));
    assign wr_hi_o  = wr_ctl && (bus_addr == ADDR_W'(OFS_CNTHI));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            scale_q <= SCALE_RST;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.cnt_en <= bus_wdata[0];
                ctrl_q.scl_en <= bus_wdata[1];
            end
            if (wr_scale) begin
                scale_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (!bus_frame) begin
            case (bus_addr)
                ADDR_W'(OFS_CTRL):  rdata_o = DATA_W'(ctrl_q);
                ADDR_W'(OFS_CNTLO): rdata_o = count_in[DATA_W-1:0];
                ADDR_W'(OFS_CNTHI): rdata_o = count_in[2*DATA_W-1:DATA_W];
                ADDR_W'(OFS_SCALE): rdata_o = scale_q;
                default:            rdata_o = '0;
            endcase
        end
    end

    assign ctrl_o  = ctrl_q;
    assign scale_o = scale_q;

endmodule

// File: rtl/ssc_accum.sv
module ssc_accum
    import ssc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64,
    parameter int FRAC_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  ssc_ctrl_t         ctrl,
    input  logic [DATA_W-1:0] scale,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count_o
);
    localparam int ACC_W = CNT_W + FRAC_W;
    localparam logic [ACC_W-1:0] UNIT_INC = ACC_W'(1) << FRAC_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] inc;

    assign inc = ctrl.scl_en ? ACC_W'(scale) : UNIT_INC;

    always_comb begin
        acc_d = acc_q;
        if (wr_lo || wr_hi) begin
            acc_d[FRAC_W-1:0] = '0;
            if (wr_lo) acc_d[FRAC_W +: DATA_W]          = wdata;
            if (wr_hi) acc_d[FRAC_W + DATA_W +: DATA_W] = wdata;
        end else if (ctrl.cnt_en && tick) begin
            acc_d = acc_q + inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign count_o = acc_q[ACC_W-1:FRAC_W];

endmodule

// File: rtl/scaled_sys_counter.sv
module scaled_sys_counter
    import ssc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 64,
    parameter int FRAC_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic              bus_frame,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  count_out
);
    ssc_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] scale_q;
    logic              wr_lo;
    logic              wr_hi;

    ssc_regfile #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_frame(bus_frame),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .count_in (count_out),
        .ctrl_o   (ctrl_q),
        .scale_o  (scale_q),
        .wr_lo_o  (wr_lo),
        .wr_hi_o  (wr_hi),
        .rdata_o  (bus_rdata)
    );

    ssc_accum #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .tick   (ref_tick),
        .ctrl   (ctrl_q),
        .scale  (scale_q),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wdata  (bus_wdata),
        .count_o(count_out)
    );

endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 64,
    parameter int FRAC_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_tick,
    input logic              bus_frame,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [CNT_W-1:0]  count_out,
    input logic              cnt_en,
    input logic              scl_en,
    input logic [DATA_W-1:0] scale_q,
    input logic              wr_lo,
    input logic              wr_hi
);
    logic idle;
    assign idle = !wr_lo && !wr_hi;

    // R2: disabled counter holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && idle) |=> $stable(count_out));

    // R3: unity step
    p_unit_step_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !scl_en && ref_tick && idle) |=> (count_out == $past(count_out) + 1'b1));

    // R4: a scaled step never exceeds the whole part of the increment plus one
    p_scaled_step_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && scl_en && ref_tick && idle) |=>
        ((count_out - $past(count_out)) <= (CNT_W'($past(scale_q) >> FRAC_W) + 1'b1)));

    // R5: low-half write
    p_wr_lo_r5: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (count_out[DATA_W-1:0] == $past(bus_wdata)) &&
                  (count_out[CNT_W-1:DATA_W] == $past(count_out[CNT_W-1:DATA_W])));

    // R6: high-half write
    p_wr_hi_r6: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (count_out[CNT_W-1:DATA_W] == $past(bus_wdata)) &&
                  (count_out[DATA_W-1:0] == $past(count_out[DATA_W-1:0])));

    // R8: reserved control bits read zero
    p_ctrl_rsvd_r8: assert property (@(posedge clk) disable iff (rst)
        (!bus_frame && bus_addr == '0) |-> (bus_rdata[DATA_W-1:2] == '0));

    // R9: status frame reads zero
    p_status_zero_r9: assert property (@(posedge clk) disable iff (rst)
        bus_frame |-> (bus_rdata == '0));

endmodule

bind scaled_sys_counter ssc_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_tick (ref_tick),
    .bus_frame(bus_frame),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .count_out(count_out),
    .cnt_en   (ctrl_q.cnt_en),
    .scl_en   (ctrl_q.scl_en),
    .scale_q  (scale_q),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi)
);

// File: tb/tb_scaled_sys_counter.sv
`timescale 1ns/1ps
module tb_scaled_sys_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_frame = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] count_out;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    scaled_sys_counter dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_wr(bus_wr),
        .bus_frame(bus_frame), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .count_out(count_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic tk = 1'b0);
        @(negedge clk);
        bus_wr = 1'b1; bus_frame = 1'b0; bus_addr = a; bus_wdata = d; ref_tick = tk;
        @(negedge clk);
        bus_wr = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic rd(input logic fr, input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_frame = fr; bus_addr = a;
        #1 d = bus_rdata;
        bus_frame = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (n) @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic set_count(input logic [63:0] v);
        wr(3'd1, v[31:0]);
        wr(3'd2, v[63:32]);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 count", count_out, 64'd0);
        rd(1'b0, 3'd0, d); check("R1 ctrl", 64'(d), 64'd0);
        rd(1'b0, 3'd3, d); check("R1 scale", 64'(d), 64'h0100_0000);
    endtask

    task automatic t_disabled;
        ticks(5);
        check("R2 hold while disabled", count_out, 64'd0);
    endtask

    task automatic t_unity;
        wr(3'd0, 32'h1);
        ticks(7);
        check("R3 unity ticks", count_out, 64'd7);
        wr(3'd0, 32'h0);
        ticks(3);
        check("R2 hold after disable", count_out, 64'd7);
    endtask

    task automatic t_scaled;
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h0080_0000);
        set_count(64'd0);
        wr(3'd0, 32'h3);
        ticks(5);
        check("R4 half rate", count_out, 64'd2);
        ticks(1);
        check("R4 half rate fraction carry", count_out, 64'd3);
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h0300_0000);
        set_count(64'd100);
        wr(3'd0, 32'h3);
        ticks(4);
        check("R4 triple rate", count_out, 64'd112);
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h0100_0000);
    endtask

    task automatic t_halves;
        logic [31:0] d;
        set_count(64'h1111_2222_3333_4444);
        wr(3'd1, 32'hAAAA_5555);
        check("R5 low write", count_out, 64'h1111_2222_AAAA_5555);
        rd(1'b0, 3'd1, d); check("R5 low readback", 64'(d), 64'hAAAA_5555);
        wr(3'd2, 32'h0BAD_F00D);
        check("R6 high write", count_out, 64'h0BAD_F00D_AAAA_5555);
        rd(1'b0, 3'd2, d); check("R6 high readback", 64'(d), 64'h0BAD_F00D);
    endtask

    task automatic t_collide;
        // fraction cleared by write: a half-scale run leaves 0.5, then write
        wr(3'd3, 32'h0080_0000);
        set_count(64'd0);
        wr(3'd0, 32'h3);
        ticks(1);
        wr(3'd1, 32'h0000_0100, 1'b1);
        check("R7 write beats tick", count_out, 64'd256);
        ticks(1);
        check("R5 fraction cleared", count_out, 64'd256);
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h0100_0000);
    endtask

    task automatic t_ctrl_bits;
        logic [31:0] d;
        wr(3'd0, 32'hFFFF_FFFC);
        rd(1'b0, 3'd0, d); check("R8 reserved write ignored", 64'(d), 64'd0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(1'b0, 3'd0, d); check("R8 reserved bits zero", 64'(d), 64'd3);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_status;
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(1'b1, 3'(a), d); check("R9 status zero", 64'(d), 64'd0);
        end
        for (int a = 4; a < 8; a++) begin
            rd(1'b0, 3'(a), d); check("R9 unused offset zero", 64'(d), 64'd0);
        end
    endtask

    task automatic t_carry;
        set_count(64'h0000_0012_FFFF_FFFF);
        wr(3'd0, 32'h1);
        ticks(1);
        check("R10 carry into high half", count_out, 64'h0000_0013_0000_0000);
        ticks(2);
        check("R10 keeps counting", count_out, 64'h0000_0013_0000_0002);
        wr(3'd0, 32'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_unity();
        t_scaled();
        t_halves();
        t_collide();
        t_ctrl_bits();
        t_status();
        t_carry();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule